// File: doc/BRIEF.md
# Negative-Cycle Detector for a Weighted Currency Graph

This block runs a single-source shortest-path sweep of the Bellman-Ford kind over a small directed graph. The graph's edge weights sit in a square weight matrix held in a memory outside the block. Row index is the edge's origin and column index is its target. Exchange rates are turned into negated logarithms before they are written to that memory, so a loop of trades whose rate product exceeds one shows up as a cycle whose weights sum below zero. The block reports whether such a cycle exists and names a vertex on which the final test failed.

A pulse on `start` launches a run from the vertex on `src_sel`. The block first fills its internal distance and predecessor tables, then makes NUM_V-1 relaxation sweeps over every matrix cell, and then one test sweep. Each cell takes three cycles: issue the matrix read, compare, write back. At the end `done` pulses, and the verdict stays on `cycle_found` and `bad_vertex` until the next run completes. A downstream loop tracer reads the predecessor chain, and the distance of any vertex, through a combinational query port.

The controller states are IDLE, INIT, READ, CMP, WRITE and DONE. IDLE moves to INIT on start. INIT always moves to READ, READ to CMP, and CMP to WRITE. WRITE moves back to READ for the next cell, or to DONE after the final cell of the test sweep. DONE returns to IDLE.

Top module: `bfd_negcycle_top`

## Requirements
- R1: Once a run starts, every vertex has predecessor "none", encoded as all ones on the index width. The selected source has distance 0 and every other vertex has distance +infinity, encoded as 0x7FFF (largest positive 16-bit value).
- R2: Cells are visited row-major: origin outer, target inner, each from 0 up. Every cell is read through the matrix port with a one-cycle read latency, and a read request never lasts two cycles in a row. A stored weight of 0 means the edge is absent, and that cell never changes any state.
- R3: Distance plus weight saturates. If either operand is +infinity the sum is +infinity, and otherwise the sum is clamped to the range -32768..32767. A written distance is always strictly below the value it replaces.
- R4: During the NUM_V-1 relaxation sweeps, an edge (i,j) whose saturated sum dist(i)+w is strictly below dist(j) sets dist(j) to that sum and pred(j) to i. The updated values are visible to later cells of the same sweep.
- R5: The test sweep writes nothing. It sets `cycle_found` if any present edge still satisfies the R4 condition. `bad_vertex` then names the target of the first such edge in R2 order, and it is 0 when no cycle is found.
- R6: `done` is high for exactly one cycle, 3·NUM_V³+1 clock cycles after the edge that samples `start`.
- R7: `start` is acted on only in IDLE. A pulse during a run changes neither the source nor the result nor the run length.
- R8: After reset `done`, `cycle_found`, `bad_vertex` and the read request are all 0. `cycle_found` and `bad_vertex` change only at the end of a run, and they hold between runs.
- R9: `q_dist` and `q_pred` show, in the same cycle, the table entries of the vertex on `q_idx`. An index outside the graph reads as +infinity and "none".
- R10: Matrix read indices, and `bad_vertex` while a cycle is reported, are always below NUM_V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a run (sampled only in IDLE) |
| src_sel | input | VW | Source vertex for the run |
| mat_rd_en | output | 1 | Weight matrix read request |
| mat_rd_row | output | VW | Edge origin (matrix row) |
| mat_rd_col | output | VW | Edge target (matrix column) |
| mat_rd_data | input | W | Signed weight, valid the cycle after the request |
| done | output | 1 | One-cycle end-of-run pulse |
| cycle_found | output | 1 | A negative-weight cycle was detected |
| bad_vertex | output | VW | Target of the first edge that failed the test |
| q_idx | input | VW | Query vertex index |
| q_dist | output | W | Distance of the queried vertex |
| q_pred | output | VW | Predecessor of the queried vertex |

## Verification
The assertions check on every cycle the things that hold whatever graph is loaded. These are the single-cycle shape of read requests and of `done`, the index ranges, that each write-back strictly lowers a distance, and that the verdict stays put outside the done pulse. What the final distances, the predecessor links, the choice of reported vertex, saturation at both ends of the range and the ignoring of a mid-run start actually are can only be shown by the bench's graphs. Those graphs include unreachable negative loops, negative self-loops, chains that clamp at both limits, and a dense matrix, each compared against a model run of the requirements.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

    // Controller states of the detector
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_INIT  = 3'd1,
        S_READ  = 3'd2,
        S_CMP   = 3'd3,
        S_WRITE = 3'd4,
        S_DONE  = 3'd5
    } bfd_state_t;

endpackage

// File: rtl/bfd_sat_add.sv
module bfd_sat_add #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] sum
);
    localparam logic signed [W-1:0] POS_INF = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        wide = {a[W-1], a} + {b[W-1], b};
        if (a == POS_INF || b == POS_INF) begin
            sum = POS_INF;
        end else if (wide[W] != wide[W-1]) begin
            // overflow: the extra sign bit tells the direction
            sum = wide[W] ? NEG_MIN : POS_INF;
        end else begin
            sum = wide[W-1:0];
        end
    end
endmodule

// File: rtl/bfd_edge_walker.sv
module bfd_edge_walker #(
    parameter int NUM_V = 8,
    parameter int VW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [VW-1:0] row,
    output logic [VW-1:0] col,
    output logic          check_pass,
    output logic          last_edge
);
    localparam int PW = (NUM_V > 2) ? $clog2(NUM_V) : 1;
    localparam logic [VW-1:0] LAST_V = VW'(NUM_V - 1);
    localparam logic [PW-1:0] LAST_P = PW'(NUM_V - 1);

    logic [PW-1:0] pass_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row    <= '0;
            col    <= '0;
            pass_q <= '0;
        end else if (clear) begin
            row    <= '0;
            col    <= '0;
            pass_q <= '0;
        end else if (step) begin
            if (col == LAST_V) begin
                col <= '0;
                if (row == LAST_V) begin
                    row    <= '0;
                    pass_q <= pass_q + 1'b1;
                end else begin
                    row <= row + 1'b1;
                end
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    assign check_pass = (pass_q == LAST_P);
    assign last_edge  = check_pass && (row == LAST_V) && (col == LAST_V);
endmodule

// File: rtl/bfd_dist_store.sv
module bfd_dist_store #(
    parameter int NUM_V = 8,
    parameter int W     = 16,
    parameter int VW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_en,
    input  logic [VW-1:0]       init_src,
    input  logic                wr_en,
    input  logic [VW-1:0]       wr_idx,
    input  logic signed [W-1:0] wr_dist,
    input  logic [VW-1:0]       wr_pred,
    input  logic [VW-1:0]       rd_a_idx,
    output logic signed [W-1:0] rd_a_dist,
    input  logic [VW-1:0]       rd_b_idx,
    output logic signed [W-1:0] rd_b_dist,
    input  logic [VW-1:0]       q_idx,
    output logic signed [W-1:0] q_dist,
    output logic [VW-1:0]       q_pred
);
    localparam logic signed [W-1:0] POS_INF = {1'b0, {(W-1){1'b1}}};
    localparam logic [VW-1:0]       NO_PRED = {VW{1'b1}};

    logic signed [W-1:0] dist_r [NUM_V];
    logic [VW-1:0]       pred_r [NUM_V];

    for (genvar v = 0; v < NUM_V; v++) begin : g_vertex
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dist_r[v] <= POS_INF;
                pred_r[v] <= NO_PRED;
            end else if (init_en) begin
                dist_r[v] <= (init_src == VW'(v)) ? '0 : POS_INF;
                pred_r[v] <= NO_PRED;
            end else if (wr_en && wr_idx == VW'(v)) begin
                dist_r[v] <= wr_dist;
                pred_r[v] <= wr_pred;
            end
        end
    end

    always_comb begin
        rd_a_dist = POS_INF;
        rd_b_dist = POS_INF;
        q_dist    = POS_INF;
        q_pred    = NO_PRED;
        for (int v = 0; v < NUM_V; v++) begin
            if (rd_a_idx == VW'(v)) rd_a_dist = dist_r[v];
            if (rd_b_idx == VW'(v)) rd_b_dist = dist_r[v];
            if (q_idx == VW'(v)) begin
                q_dist = dist_r[v];
                q_pred = pred_r[v];
            end
        end
    end
endmodule

// File: rtl/bfd_negcycle_top.sv
module bfd_negcycle_top
    import bfd_pkg::*;
#(
    parameter int NUM_V = 8,
    parameter int W     = 16,
    localparam int VW   = $clog2(NUM_V + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VW-1:0]       src_sel,
    output logic                mat_rd_en,
    output logic [VW-1:0]       mat_rd_row,
    output logic [VW-1:0]       mat_rd_col,
    input  logic signed [W-1:0] mat_rd_data,
    output logic                done,
    output logic                cycle_found,
    output logic [VW-1:0]       bad_vertex,
    input  logic [VW-1:0]       q_idx,
    output logic signed [W-1:0] q_dist,
    output logic [VW-1:0]       q_pred
);
    bfd_state_t state, state_nxt;

    logic [VW-1:0]       src_q;
    logic [VW-1:0]       row, col;
    logic                check_pass, last_edge;
    logic                walk_clear, walk_step;
    logic                init_en;
    logic                upd_en;
    logic signed [W-1:0] upd_dist;
    logic signed [W-1:0] src_dist, dst_dist;
    logic signed [W-1:0] cand;
    logic                better;
    logic signed [W-1:0] cand_q;
    logic                better_q;
    logic                found_run;
    logic [VW-1:0]       bad_run;
    logic                test_hit;

    bfd_edge_walker #(.NUM_V(NUM_V), .VW(VW)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (walk_clear),
        .step       (walk_step),
        .row        (row),
        .col        (col),
        .check_pass (check_pass),
        .last_edge  (last_edge)
    );

    bfd_dist_store #(.NUM_V(NUM_V), .W(W), .VW(VW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_en   (init_en),
        .init_src  (src_q),
        .wr_en     (upd_en),
        .wr_idx    (col),
        .wr_dist   (upd_dist),
        .wr_pred   (row),
        .rd_a_idx  (row),
        .rd_a_dist (src_dist),
        .rd_b_idx  (col),
        .rd_b_dist (dst_dist),
        .q_idx     (q_idx),
        .q_dist    (q_dist),
        .q_pred    (q_pred)
    );

    bfd_sat_add #(.W(W)) u_add (
        .a   (src_dist),
        .b   (mat_rd_data),
        .sum (cand)
    );

    // a stored zero marks an absent edge
    assign better   = (mat_rd_data != '0) && (cand < dst_dist);
    assign upd_dist = cand_q;
    assign test_hit = check_pass && better_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (start) state_nxt = S_INIT;
            S_INIT:  state_nxt = S_READ;
            S_READ:  state_nxt = S_CMP;
            S_CMP:   state_nxt = S_WRITE;
            S_WRITE: state_nxt = last_edge ? S_DONE : S_READ;
            S_DONE:  state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // state-decoded outputs and strobes
    always_comb begin
        mat_rd_en  = 1'b0;
        done       = 1'b0;
        walk_clear = 1'b0;
        walk_step  = 1'b0;
        init_en    = 1'b0;
        upd_en     = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_INIT: begin
                init_en    = 1'b1;
                walk_clear = 1'b1;
            end
            S_READ:  mat_rd_en = 1'b1;
            S_CMP:   ;
            S_WRITE: begin
                walk_step = 1'b1;
                upd_en    = better_q && !check_pass;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign mat_rd_row = row;
    assign mat_rd_col = col;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q       <= '0;
            cand_q      <= '0;
            better_q    <= 1'b0;
            found_run   <= 1'b0;
            bad_run     <= '0;
            cycle_found <= 1'b0;
            bad_vertex  <= '0;
        end else begin
            if (state == S_IDLE && start) src_q <= src_sel;
            if (state == S_INIT) begin
                found_run <= 1'b0;
                bad_run   <= '0;
            end
            if (state == S_CMP) begin
                cand_q   <= cand;
                better_q <= better;
            end
            if (state == S_WRITE) begin
                if (test_hit && !found_run) begin
                    found_run <= 1'b1;
                    bad_run   <= col;
                end
                if (last_edge) begin
                    cycle_found <= found_run || test_hit;
                    if (found_run)     bad_vertex <= bad_run;
                    else if (test_hit) bad_vertex <= col;
                    else               bad_vertex <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bfd_checker.sv
module bfd_checker #(
    parameter int NUM_V = 8,
    parameter int W     = 16,
    parameter int VW    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done,
    input logic                cycle_found,
    input logic [VW-1:0]       bad_vertex,
    input logic                mat_rd_en,
    input logic [VW-1:0]       mat_rd_row,
    input logic [VW-1:0]       mat_rd_col,
    input logic                upd_en,
    input logic signed [W-1:0] upd_dist,
    input logic signed [W-1:0] cur_dist
);
    localparam logic [VW-1:0] LAST_V = VW'(NUM_V - 1);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_read_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mat_rd_en |=> !mat_rd_en);

    assert_read_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mat_rd_en |-> (mat_rd_row <= LAST_V && mat_rd_col <= LAST_V));

    assert_write_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> (upd_dist < cur_dist));

    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cycle_found) && $stable(bad_vertex)));

    assert_vertex_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_found |-> (bad_vertex <= LAST_V));
endmodule

bind bfd_negcycle_top bfd_checker #(.NUM_V(NUM_V), .W(W), .VW(VW)) u_bfd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .cycle_found (cycle_found),
    .bad_vertex  (bad_vertex),
    .mat_rd_en   (mat_rd_en),
    .mat_rd_row  (mat_rd_row),
    .mat_rd_col  (mat_rd_col),
    .upd_en      (upd_en),
    .upd_dist    (upd_dist),
    .cur_dist    (dst_dist)
);

// File: tb/test_bfd_negcycle_top.sv
`timescale 1ns/1ps
module test_bfd_negcycle_top;
    localparam int NV   = 8;
    localparam int VW   = 4;
    localparam int INF  = 32767;
    localparam int NONE = 15;
    localparam int RUN_LEN = 3 * NV * NV * NV + 1;
    localparam int NVEC = 11;
    // table: source, graph pattern, expected verdict (2 = only from model)
    localparam int TAB_SRC   [NVEC] = '{0, 0, 3, 0, 1, 0, 6, 0, 0, 2, 0};
    localparam int TAB_PAT   [NVEC] = '{0, 1, 1, 2, 3, 4, 4, 5, 6, 7, 8};
    localparam int TAB_FOUND [NVEC] = '{0, 0, 0, 1, 1, 0, 1, 0, 0, 1, 2};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [VW-1:0]       src_sel = '0;
    logic                mat_rd_en;
    logic [VW-1:0]       mat_rd_row, mat_rd_col;
    logic signed [15:0]  mat_rd_data;
    logic                done, cycle_found;
    logic [VW-1:0]       bad_vertex;
    logic [VW-1:0]       q_idx = '0;
    logic signed [15:0]  q_dist;
    logic [VW-1:0]       q_pred;

    logic signed [15:0]  mem [NV][NV];
    int n_cmp = 0;
    int n_bad = 0;
    int m_dist [NV];
    int m_pred [NV];
    int m_found, m_vtx;

    always #4 clk = ~clk;

    bfd_negcycle_top #(.NUM_V(NV), .W(16)) i_bfd_negcycle_top (
        .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel),
        .mat_rd_en(mat_rd_en), .mat_rd_row(mat_rd_row), .mat_rd_col(mat_rd_col),
        .mat_rd_data(mat_rd_data), .done(done), .cycle_found(cycle_found),
        .bad_vertex(bad_vertex), .q_idx(q_idx), .q_dist(q_dist), .q_pred(q_pred)
    );

    // weight memory, one-cycle read latency
    always_ff @(posedge clk) begin
        if (mat_rd_en) mat_rd_data <= mem[int'(mat_rd_row)][int'(mat_rd_col)];
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bsat(input int a, input int b);
        int s;
        if (a == INF || b == INF) return INF;
        s = a + b;
        if (s > INF) return INF;
        if (s < -32768) return -32768;
        return s;
    endfunction

    task automatic load_pattern(input int pat);
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++) mem[i][j] = 16'sd0;
        case (pat)
            1: for (int i = 0; i < NV - 1; i++) mem[i][i+1] = 16'sd5;
            2: begin
                mem[0][2] = 16'sd1;  mem[2][3] = 16'sd3;
                mem[3][4] = -16'sd2; mem[4][2] = -16'sd4;
            end
            3: begin mem[1][5] = 16'sd2; mem[5][5] = -16'sd1; end
            4: begin mem[0][1] = 16'sd2; mem[6][7] = -16'sd3; mem[7][6] = 16'sd1; end
            5: begin mem[0][1] = -16'sd30000; mem[1][2] = -16'sd30000; end
            6: begin mem[0][1] = 16'sd32000; mem[1][2] = 16'sd32000; mem[0][3] = 16'sd100; end
            7: begin mem[0][1] = -16'sd10; mem[1][2] = 16'sd4; mem[2][0] = 16'sd5; end
            8: for (int i = 0; i < NV; i++)
                   for (int j = 0; j < NV; j++)
                       if (i != j) mem[i][j] = 16'(((i * 5 + j * 3) % 11) - 2);
            default: ;
        endcase
    endtask

    task automatic run_model(input int src);
        int c;
        for (int v = 0; v < NV; v++) begin
            m_dist[v] = (v == src) ? 0 : INF;
            m_pred[v] = NONE;
        end
        for (int p = 0; p < NV - 1; p++)
            for (int i = 0; i < NV; i++)
                for (int j = 0; j < NV; j++)
                    if (mem[i][j] != 0) begin
                        c = bsat(m_dist[i], int'(mem[i][j]));
                        if (c < m_dist[j]) begin
                            m_dist[j] = c;
                            m_pred[j] = i;
                        end
                    end
        m_found = 0;
        m_vtx = 0;
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++)
                if (mem[i][j] != 0 && m_found == 0)
                    if (bsat(m_dist[i], int'(mem[i][j])) < m_dist[j]) begin
                        m_found = 1;
                        m_vtx = j;
                    end
    endtask

    // launch a run; optionally pulse start again at cycle mid_at with another source
    task automatic do_run(input int src, input int mid_at, input int mid_src, output int cyc);
        @(negedge clk);
        src_sel = VW'(src);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 6000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (cyc == mid_at) begin
                src_sel = VW'(mid_src);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
    endtask

    task automatic check_results(input string tag);
        chk({tag, " R5 verdict"}, int'(cycle_found), m_found);
        chk({tag, " R5 vertex"}, int'(bad_vertex), m_vtx);
        for (int v = 0; v < NV; v++) begin
            q_idx = VW'(v);
            #1;
            chk({tag, " R4 distance"}, int'(q_dist), m_dist[v]);
            chk({tag, " R4 predecessor"}, int'(q_pred), m_pred[v]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        for (int i = 0; i < NV; i++)
            for (int j = 0; j < NV; j++) mem[i][j] = 16'sd0;
        repeat (3) @(negedge clk);
        // reset state
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset verdict", int'(cycle_found), 0);
        chk("R8 reset vertex", int'(bad_vertex), 0);
        chk("R8 reset read request", int'(mat_rd_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            load_pattern(TAB_PAT[k]);
            run_model(TAB_SRC[k]);
            do_run(TAB_SRC[k], -1, 0, cyc);
            chk($sformatf("vec%0d R6 run length", k), cyc, RUN_LEN);
            if (TAB_FOUND[k] != 2)
                chk($sformatf("vec%0d R5 table verdict", k), int'(cycle_found), TAB_FOUND[k]);
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("vec%0d R6 done width", k), int'(done), 0);
            check_results($sformatf("vec%0d", k));
        end

        // R1 initial table: empty graph from source 4
        load_pattern(0);
        do_run(4, -1, 0, cyc);
        for (int v = 0; v < NV; v++) begin
            q_idx = VW'(v);
            #1;
            chk("R1 init distance", int'(q_dist), (v == 4) ? 0 : INF);
            chk("R1 init predecessor", int'(q_pred), NONE);
        end
        // R9 out-of-range query
        q_idx = VW'(12);
        #1;
        chk("R9 query outside graph dist", int'(q_dist), INF);
        chk("R9 query outside graph pred", int'(q_pred), NONE);

        // R3 saturation: chain clamps low, infinite sum stays unreached
        load_pattern(5);
        do_run(0, -1, 0, cyc);
        q_idx = VW'(2);
        #1;
        chk("R3 clamp low", int'(q_dist), -32768);
        load_pattern(6);
        do_run(0, -1, 0, cyc);
        q_idx = VW'(2);
        #1;
        chk("R3 clamp high dist", int'(q_dist), INF);
        chk("R3 clamp high pred", int'(q_pred), NONE);

        // R2 zero weight means no edge: a zero on the source row leaves target unreached
        load_pattern(0);
        mem[0][1] = 16'sd0;
        mem[0][2] = 16'sd7;
        do_run(0, -1, 0, cyc);
        q_idx = VW'(1);
        #1;
        chk("R2 zero cell absent", int'(q_dist), INF);
        q_idx = VW'(2);
        #1;
        chk("R2 present cell used", int'(q_dist), 7);

        // R7 start during a run is ignored
        load_pattern(7);
        run_model(2);
        do_run(2, 100, 5, cyc);
        chk("R7 run length with extra start", cyc, RUN_LEN);
        check_results("R7");

        // R8 verdict holds between runs, then a clean run clears it
        repeat (20) @(negedge clk);
        chk("R8 verdict held", int'(cycle_found), 1);
        chk("R8 vertex held", int'(bad_vertex), m_vtx);
        load_pattern(1);
        do_run(0, -1, 0, cyc);
        chk("R8 verdict replaced", int'(cycle_found), 0);
        chk("R8 vertex replaced", int'(bad_vertex), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule